// File: doc/BRIEF.md
# Wear-Out Damage Accumulator and Projector

This block keeps a running lifetime-consumption figure for several independent wear-out mechanisms, one channel per mechanism. Upstream logic supplies, with every sample, the damage each mechanism took during the last interval. That damage is the interval length times the ratio of reference lifetime to lifetime at the present stress, so thermal-cycling swings arrive already expressed as an equivalent fraction of a reference swing. The upstream logic also supplies the interval length in time units. The block adds the damage terms, counts elapsed time, and extrapolates each channel linearly to a target lifetime.

Each projected damage figure goes through a per-channel damage-to-probability curve. The curve is a 16-point table with linear interpolation between points. The channels are then combined as independent survival terms into one chip failure probability. A supervisory controller uses that probability to decide how far the supply voltage may be raised.

All data values are unsigned Q1.15, where 0x8000 represents 1.0. A single strobe updates every channel at once. The combined probability follows on a fixed pipeline.

Top module: `wear_projector`

## Requirements
- R1: A synchronous reset clears all damage accumulators, the elapsed-time counter, `pf_vld` and `chip_pf`. The table is not cleared. After reset, a sample with zero damage projects zero damage, so every channel reads table entry 0.
- R2: On each strobe, each channel adds its 16-bit increment, taken from `smp_inc[16c+15:16c]` for channel c, to its accumulator. The accumulator saturates at 0xFFFF instead of wrapping.
- R3: On each strobe, the elapsed-time counter adds `smp_dt` and saturates at all ones.
- R4: Projected damage per channel is floor(accumulator × `life_tgt` / elapsed), using the values left by the strobe. The result saturates at 0xFFFF.
- R5: When elapsed time is zero after a strobe, the projection is suppressed and that strobe's `chip_pf` is 0.
- R6: Projected damage d selects table entry i = d[15:12] and fraction f = d[11:0]. The probability is e[i] + floor((e[i+1] − e[i]) × f / 4096), and for i = 15 the next entry is e[15] itself.
- R7: Each channel probability is capped at 0x8000. A survival value s starts at 0x8000 and, for channels 0 upward in order, becomes floor(s × (0x8000 − p) / 2^15). `chip_pf` = 0x8000 − s, so `chip_pf` never exceeds 0x8000.
- R8: A strobe sampled at clock edge n gives a one-cycle `pf_vld` pulse and its `chip_pf` after edge n+3, four cycles after the strobe cycle. Back-to-back strobes give back-to-back results in order, and no `pf_vld` appears without a strobe.
- R9: With `tbl_we` high, entry `tbl_idx` of channel `tbl_ch` takes `tbl_data` at the clock edge, and later samples use the new entry. A channel number at or above the channel count writes nothing.
- R10: Without a strobe, the accumulators and the elapsed-time counter hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_vld | input | 1 | Sample strobe, updates all channels |
| smp_inc | input | NCH*16 | Per-channel Q1.15 damage increments |
| smp_dt | input | DTW | Interval length added to elapsed time |
| life_tgt | input | TW | Target lifetime in elapsed-time units |
| tbl_we | input | 1 | Curve table write enable |
| tbl_ch | input | CW | Channel selected for table write |
| tbl_idx | input | 4 | Table entry selected for write |
| tbl_data | input | 16 | Q1.15 probability written to the table |
| pf_vld | output | 1 | Combined probability valid pulse |
| chip_pf | output | 16 | Combined chip failure probability, Q1.15 |

## Verification
Each strobe's result is due exactly four cycles after the cycle in which the strobe is driven. That is the accumulate, project, interpolate and combine stages, one register each. The driver stamps every expected value with that due cycle when it queues it. The monitor samples on the falling edge and fails both a result that arrives early and one that has not arrived by its due cycle. Table writes and target-lifetime changes are made only while the pipeline is empty, because the projection stage reads `life_tgt` one cycle after the strobe.

// File: rtl/wear_projector.sv
module wear_projector #(
  parameter int NCH = 3,
  parameter int TW = 24,
  parameter int DTW = 8,
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             smp_vld,
  input  logic [NCH*16-1:0] smp_inc,
  input  logic [DTW-1:0]   smp_dt,
  input  logic [TW-1:0]    life_tgt,
  input  logic             tbl_we,
  input  logic [CW-1:0]    tbl_ch,
  input  logic [3:0]       tbl_idx,
  input  logic [15:0]      tbl_data,
  output logic             pf_vld,
  output logic [15:0]      chip_pf
);
  localparam int PW = 16 + TW;

  logic [NCH-1:0][15:0] acc_q, acc_nx, prj_q, prj_nx, prb_q, prb_nx;
  logic [TW-1:0] el_q, el_nx;
  logic [TW:0]   el_sum;
  logic          v1, v2, v3, z2, z3;
  logic [15:0]   tbl [NCH][16];
  logic [NCH:0][16:0] sv;

  assign el_sum = {1'b0, el_q} + (TW+1)'(smp_dt);
  assign el_nx  = el_sum[TW] ? '1 : el_sum[TW-1:0];
  assign sv[0]  = 17'h08000;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [16:0] a_sum;
    logic [PW-1:0] num, den, quo;
    logic [3:0] ix;
    logic [11:0] fr;
    logic [15:0] ea, eb;
    logic signed [29:0] dlt, mul, itp;
    logic [33:0] m;

    assign a_sum     = {1'b0, acc_q[c]} + {1'b0, smp_inc[c*16 +: 16]};
    assign acc_nx[c] = a_sum[16] ? 16'hFFFF : a_sum[15:0];

    assign num = PW'(acc_q[c]) * PW'(life_tgt);
    assign den = (el_q == '0) ? PW'(1) : PW'(el_q);
    assign quo = num / den;
    assign prj_nx[c] = (el_q == '0) ? 16'h0 : ((|quo[PW-1:16]) ? 16'hFFFF : quo[15:0]);

    assign ix  = prj_q[c][15:12];
    assign fr  = prj_q[c][11:0];
    assign ea  = tbl[c][ix];
    assign eb  = (ix == 4'hF) ? ea : tbl[c][ix + 4'd1];
    assign dlt = $signed({14'b0, eb}) - $signed({14'b0, ea});
    assign mul = dlt * $signed({18'b0, fr});
    assign itp = $signed({14'b0, ea}) + (mul >>> 12);
    assign prb_nx[c] = (itp > 30'sd32768) ? 16'h8000 : itp[15:0];

    assign m = 34'(sv[c]) * 34'(17'h08000 - {1'b0, prb_q[c]});
    assign sv[c+1] = 17'(m >> 15);
  end

  always_ff @(posedge clk) begin
    if (tbl_we && int'(tbl_ch) < NCH) tbl[tbl_ch][tbl_idx] <= tbl_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q   <= '0;
      el_q    <= '0;
      v1      <= 1'b0;
      v2      <= 1'b0;
      v3      <= 1'b0;
      pf_vld  <= 1'b0;
      chip_pf <= '0;
    end else begin
      v1     <= smp_vld;
      v2     <= v1;
      v3     <= v2;
      pf_vld <= v3;
      if (smp_vld) begin
        acc_q <= acc_nx;
        el_q  <= el_nx;
      end
      if (v3) chip_pf <= z3 ? 16'h0 : 16'(17'h08000 - sv[NCH]);
    end
  end

  always_ff @(posedge clk) begin
    z2    <= (el_q == '0);
    z3    <= z2;
    prj_q <= prj_nx;
    prb_q <= prb_nx;
  end
endmodule

// File: rtl/wear_projector_chk.sv
module wear_projector_chk #(
  parameter int NCH = 3,
  parameter int TW = 24
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 smp_vld,
  input logic                 pf_vld,
  input logic [15:0]          chip_pf,
  input logic [NCH-1:0][15:0] acc_q,
  input logic [TW-1:0]        el_q
);
  logic [2:0] run;
  always_ff @(posedge clk) begin
    if (rst) run <= 3'd0;
    else if (run != 3'd4) run <= run + 3'd1;
  end

  p_latency_r8: assert property (@(posedge clk) disable iff (rst)
    (run == 3'd4) |-> (pf_vld == $past(smp_vld, 4)));

  p_range_r7: assert property (@(posedge clk) disable iff (rst)
    pf_vld |-> (chip_pf <= 16'h8000));

  p_zero_el_r5: assert property (@(posedge clk) disable iff (rst)
    (run == 3'd4 && pf_vld && $past(el_q, 3) == '0) |-> (chip_pf == 16'h0));

  p_el_mono_r3: assert property (@(posedge clk) disable iff (rst)
    smp_vld |=> (el_q >= $past(el_q)));

  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !smp_vld |=> ($stable(el_q) && $stable(acc_q)));

  for (genvar c = 0; c < NCH; c++) begin : g_acc
    p_no_wrap_r2: assert property (@(posedge clk) disable iff (rst)
      smp_vld |=> (acc_q[c] >= $past(acc_q[c])));
  end
endmodule

bind wear_projector wear_projector_chk #(.NCH(NCH), .TW(TW)) u_chk (
  .clk(clk), .rst(rst), .smp_vld(smp_vld), .pf_vld(pf_vld),
  .chip_pf(chip_pf), .acc_q(acc_q), .el_q(el_q)
);

// File: tb/sim_wear_projector.sv
`timescale 1ns/1ps
module sim_wear_projector;
  localparam int NCH = 3, TW = 10, DTW = 8;
  localparam longint ELMAX = (64'd1 << TW) - 1;

  logic clk = 1'b0, rst = 1'b1, smp_vld = 1'b0, tbl_we = 1'b0;
  logic [NCH*16-1:0] smp_inc = '0;
  logic [DTW-1:0] smp_dt = '0;
  logic [TW-1:0] life_tgt = '0;
  logic [1:0] tbl_ch = '0;
  logic [3:0] tbl_idx = '0;
  logic [15:0] tbl_data = '0;
  logic pf_vld;
  logic [15:0] chip_pf;

  always #2 clk = ~clk;

  wear_projector #(.NCH(NCH), .TW(TW), .DTW(DTW)) u0 (
    .clk(clk), .rst(rst), .smp_vld(smp_vld), .smp_inc(smp_inc), .smp_dt(smp_dt),
    .life_tgt(life_tgt), .tbl_we(tbl_we), .tbl_ch(tbl_ch), .tbl_idx(tbl_idx),
    .tbl_data(tbl_data), .pf_vld(pf_vld), .chip_pf(chip_pf)
  );

  typedef struct { int due; longint val; string tag; } item_t;
  item_t exp_q[$];
  int cyc = 0, n_chk = 0, n_bad = 0;
  bit done = 1'b0;
  longint acc_m[NCH], el_m, tgt_m, tb_m[NCH][16];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(string tag, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    item_t it;
    if (!rst) begin
      if (pf_vld) begin
        if (exp_q.size() == 0) check("R8 valid without strobe", 1, 0);
        else begin
          it = exp_q.pop_front();
          check(it.tag, longint'(chip_pf), it.val);
          check("R8 result cycle", cyc, it.due);
        end
      end else if (exp_q.size() > 0 && exp_q[0].due <= cyc) begin
        it = exp_q.pop_front();
        check({"R8 missing valid for ", it.tag}, 0, 1);
      end
    end
  end

  task automatic tload(int ch, int ix, longint v);
    tbl_we = 1'b1; tbl_ch = 2'(ch); tbl_idx = 4'(ix); tbl_data = 16'(v);
    if (ch < NCH) tb_m[ch][ix] = v;
    @(negedge clk);
    tbl_we = 1'b0;
  endtask

  task automatic idle(int n);
    smp_vld = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic samp(longint i0, longint i1, longint i2, longint dt, string tag);
    longint inc[NCH];
    longint s, pr, ix, fr, a, b, p;
    item_t it;
    inc[0] = i0; inc[1] = i1; inc[2] = i2;
    for (int c = 0; c < NCH; c++) begin
      acc_m[c] = acc_m[c] + inc[c];
      if (acc_m[c] > 65535) acc_m[c] = 65535;
    end
    el_m = el_m + dt;
    if (el_m > ELMAX) el_m = ELMAX;
    s = 32768;
    for (int c = 0; c < NCH; c++) begin
      if (el_m == 0) pr = 0;
      else pr = (acc_m[c] * tgt_m) / el_m;
      if (pr > 65535) pr = 65535;
      ix = pr >> 12;
      fr = pr & 4095;
      a = tb_m[c][ix];
      b = (ix == 15) ? a : tb_m[c][ix + 1];
      p = a + (((b - a) * fr) >>> 12);
      if (p > 32768) p = 32768;
      s = (s * (32768 - p)) >> 15;
    end
    it.due = cyc + 4;
    it.val = (el_m == 0) ? 0 : 32768 - s;
    it.tag = tag;
    exp_q.push_back(it);
    smp_vld = 1'b1;
    smp_inc = {16'(i2), 16'(i1), 16'(i0)};
    smp_dt = DTW'(dt);
    @(negedge clk);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
  endtask

  initial begin
    for (int c = 0; c < NCH; c++) begin
      acc_m[c] = 0;
      for (int i = 0; i < 16; i++) tb_m[c][i] = 0;
    end
    el_m = 0;
    tgt_m = 0;
    repeat (3) @(negedge clk);
    check("R1 reset pf_vld", longint'(pf_vld), 0);
    check("R1 reset chip_pf", longint'(chip_pf), 0);
    rst = 1'b0;
    for (int i = 0; i < 16; i++) begin
      tload(0, i, i * 2048);
      tload(1, i, 500 + i * i * 100);
      tload(2, i, (i < 8) ? i * 3000 : 40000);
    end
    life_tgt = 8; tgt_m = 8;
    @(negedge clk);
    samp(100, 200, 300, 0, "R5 zero elapsed suppresses projection");
    samp(1000, 50, 4000, 2, "R4 projection by target over elapsed");
    samp(3000, 9000, 700, 1, "R8 back-to-back result");
    samp(20, 7000, 5000, 1, "R6 interpolation and R7 clamp");
    idle(8);
    samp(0, 0, 0, 0, "R10 idle cycles leave state unchanged");
    idle(4);
    life_tgt = 1000; tgt_m = 1000;
    @(negedge clk);
    samp(0, 0, 0, 1, "R4 saturated projection R6 top entry");
    idle(4);
    tload(0, 15, 1234);
    tload(1, 15, 9999);
    samp(0, 0, 0, 0, "R9 rewritten table entries");
    idle(4);
    life_tgt = 8; tgt_m = 8;
    @(negedge clk);
    samp(16'hF000, 16'hF000, 16'hF000, 1, "R2 large increment");
    samp(16'hF000, 16'hF000, 16'hF000, 1, "R2 accumulator saturation");
    idle(4);
    for (int k = 0; k < 5; k++) samp(0, 0, 0, 255, "R3 elapsed saturation");
    idle(8);
    rst = 1'b1;
    for (int c = 0; c < NCH; c++) acc_m[c] = 0;
    el_m = 0;
    repeat (2) @(negedge clk);
    check("R1 mid-run reset pf_vld", longint'(pf_vld), 0);
    check("R1 mid-run reset chip_pf", longint'(chip_pf), 0);
    rst = 1'b0;
    @(negedge clk);
    samp(0, 0, 0, 1, "R1 cleared accumulators read entry 0");
    idle(8);
    check("R8 all results delivered", exp_q.size(), 0);
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog R8: got timeout expected completion");
      summary();
      $finish;
    end
  end
endmodule